// File: doc/BRIEF.md
# Dual-Port Host Watchdog with Shared Indicator Pin

This block holds one watchdog timer for each port of a two-port network controller. Once the host driver has confirmed that the hardware works, it must keep signalling "alive" to each port's timer. If a timer counts down to zero without that signal, the block raises an interrupt towards the management firmware. It also drives a general-purpose pin that both ports share. Software can also trip a watchdog at once with a force bit. It can record a short cause code, which stays readable as the reason for the trip.

Each timer counts in units of a prescaled tick, one tick every `TICK_DIV` clocks. The timeout width, the cause-code width and the port count are parameters. When reset is active, each timer takes its enable and its timeout from two configuration inputs, so a watchdog can be running as soon as reset ends. Three control inputs set how the shared pin behaves: a watchdog-select bit, a direction bit and a data bit that doubles as the active level of the indication.

Top module: `dual_wdt`

## Requirements
- R1: While `rst_n` is low, every port takes its enable from `cfg_en_dflt` and its timeout and count from `cfg_tmo_dflt`, and `fw_irq` is all zeros. Counting starts with the first clock edge after reset.
- R2: A pulse on `setup_wr[p]` loads port p's enable from `setup_en` and its timeout from `setup_tmo`, and reloads its count to `setup_tmo`, at the next clock edge.
- R3: A port that is enabled and has a non-zero timeout T sets `fw_irq[p]` at the edge of the T-th tick after it was last loaded. A tick is the edge where the prescaler, which counts clocks from 0 after reset, is at `TICK_DIV-1`.
- R4: A pulse on `stat_wr[p]` with `stat_alive` high reloads port p's count to its timeout and clears `fw_irq[p]` at the next edge. No expiry occurs while this repeats faster than the timeout.
- R5: A pulse on `stat_wr[p]` with `stat_force` high sets `fw_irq[p]` at the next edge if port p is enabled. If the same write also carries `stat_alive`, the force wins.
- R6: Every `stat_wr[p]` pulse stores `stat_cause` into bits `[p*CAUSE_W +: CAUSE_W]` of `trip_cause`, which then holds that value.
- R7: A port with timeout zero never expires by counting.
- R8: Once set, `fw_irq[p]` stays high until an alive write or a setup write with `setup_en` low. A disabled port neither counts nor accepts a force.
- R9: `gp0_oe` equals `gp0_dir_out`. When `gp0_dir_out` is low, `gp0_out` is 0.
- R10: With `gp0_dir_out` and `gp0_wdog_sel` high, `gp0_out` equals `gp0_level` while any port's `fw_irq` is high, and equals `~gp0_level` otherwise.
- R11: With `gp0_dir_out` high and `gp0_wdog_sel` low, `gp0_out` equals `gp0_level` regardless of the watchdog state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_en_dflt | input | 1 | Enable value loaded into every port during reset |
| cfg_tmo_dflt | input | TMO_W | Timeout value loaded into every port during reset |
| setup_wr | input | NPORTS | Per-port strobe for a setup write |
| setup_en | input | 1 | Enable value carried by a setup write |
| setup_tmo | input | TMO_W | Timeout carried by a setup write, in ticks |
| stat_wr | input | NPORTS | Per-port strobe for a status write |
| stat_alive | input | 1 | Re-arm request carried by a status write |
| stat_force | input | 1 | Immediate-trip request carried by a status write |
| stat_cause | input | CAUSE_W | Cause code carried by a status write |
| gp0_wdog_sel | input | 1 | Pin shows the watchdog indication instead of its data bit |
| gp0_dir_out | input | 1 | Pin direction, 1 = output |
| gp0_level | input | 1 | Pin data bit, also the active level of the indication |
| fw_irq | output | NPORTS | Per-port expiry interrupt to firmware |
| trip_cause | output | NPORTS*CAUSE_W | Stored cause codes, port p in slice p |
| gp0_out | output | 1 | Shared pin output value |
| gp0_oe | output | 1 | Shared pin output enable |

## Verification
Setup and status writes act at the clock edge that samples them. A forced trip or an alive re-arm is therefore visible on `fw_irq` at the falling edge that follows that edge. An expiry appears right after the edge of the T-th tick. The bench tracks the prescaler phase by counting edges from the release of reset, and so it knows which edges are ticks. The shared pin decodes the interrupt register with no logic clocked in between, so `gp0_out` and `gp0_oe` change within the same cycle as `fw_irq` or the control inputs. The bench drives inputs on the falling edge and samples one nanosecond later, well before the next rising edge. It sweeps every timeout in a four-bit configuration and every combination of the pin controls against each trip pattern.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    // How the shared pin is driven
    typedef enum logic [1:0] {
        PIN_OFF  = 2'd0,
        PIN_GPIO = 2'd1,
        PIN_WDOG = 2'd2
    } pin_mode_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == LAST);
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
    parameter int TMO_W   = 8,
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               dflt_en_i,
    input  logic [TMO_W-1:0]   dflt_tmo_i,
    input  logic               setup_wr_i,
    input  logic               setup_en_i,
    input  logic [TMO_W-1:0]   setup_tmo_i,
    input  logic               stat_wr_i,
    input  logic               stat_alive_i,
    input  logic               stat_force_i,
    input  logic [CAUSE_W-1:0] stat_cause_i,
    output logic               trip_o,
    output logic [CAUSE_W-1:0] cause_o
);
    typedef struct packed {
        logic               en;
        logic [TMO_W-1:0]   tmo;
        logic [TMO_W-1:0]   cnt;
        logic               trip;
        logic [CAUSE_W-1:0] cause;
    } wd_state_t;

    wd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // countdown on each tick while armed
        if (tick_i && st_q.en && (st_q.tmo != '0) && !st_q.trip) begin
            if (st_q.cnt <= TMO_W'(1)) begin
                st_d.cnt  = '0;
                st_d.trip = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        // status write: cause, re-arm, force (force wins)
        if (stat_wr_i) begin
            st_d.cause = stat_cause_i;
            if (stat_alive_i) begin
                st_d.cnt  = st_q.tmo;
                st_d.trip = 1'b0;
            end
            if (stat_force_i && st_q.en) st_d.trip = 1'b1;
        end
        // setup write: new enable and period, count reloaded
        if (setup_wr_i) begin
            st_d.en  = setup_en_i;
            st_d.tmo = setup_tmo_i;
            st_d.cnt = setup_tmo_i;
            if (!setup_en_i) st_d.trip = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.en    <= dflt_en_i;
            st_q.tmo   <= dflt_tmo_i;
            st_q.cnt   <= dflt_tmo_i;
            st_q.trip  <= 1'b0;
            st_q.cause <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trip_o  = st_q.trip;
    assign cause_o = st_q.cause;

    // R3
    trip_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.trip) |-> $past((tick_i && st_q.en) || (stat_wr_i && stat_force_i)));
    // R4
    rearm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_i && stat_alive_i && !(stat_force_i && st_q.en)) |=> !st_q.trip);
    // R5
    force_trips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_i && stat_force_i && st_q.en && !(setup_wr_i && !setup_en_i)) |=> st_q.trip);
    // R7
    zero_tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tmo == '0 && !st_q.trip && !(stat_wr_i && stat_force_i)) |=> !st_q.trip);
    // R8
    trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.trip && !(stat_wr_i && stat_alive_i) && !(setup_wr_i && !setup_en_i)) |=> st_q.trip);
endmodule

// File: rtl/wdt_pin.sv
module wdt_pin
    import wdt_pkg::*;
#(
    parameter int NPORTS = 2
) (
    input  logic [NPORTS-1:0] trip_i,
    input  logic              wdog_sel_i,
    input  logic              dir_out_i,
    input  logic              level_i,
    output logic              pin_o,
    output logic              oe_o
);
    pin_mode_e mode;
    logic      any_trip;

    always_comb begin
        any_trip = |trip_i;
        if (!dir_out_i)     mode = PIN_OFF;
        else if (wdog_sel_i) mode = PIN_WDOG;
        else                mode = PIN_GPIO;
        unique case (mode)
            PIN_WDOG: pin_o = any_trip ? level_i : ~level_i;
            PIN_GPIO: pin_o = level_i;
            default:  pin_o = 1'b0;
        endcase
        oe_o = dir_out_i;
    end
endmodule

// File: rtl/dual_wdt.sv
module dual_wdt #(
    parameter int NPORTS   = 2,
    parameter int TMO_W    = 8,
    parameter int CAUSE_W  = 4,
    parameter int TICK_DIV = 1000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_en_dflt,
    input  logic [TMO_W-1:0]          cfg_tmo_dflt,
    input  logic [NPORTS-1:0]         setup_wr,
    input  logic                      setup_en,
    input  logic [TMO_W-1:0]          setup_tmo,
    input  logic [NPORTS-1:0]         stat_wr,
    input  logic                      stat_alive,
    input  logic                      stat_force,
    input  logic [CAUSE_W-1:0]        stat_cause,
    input  logic                      gp0_wdog_sel,
    input  logic                      gp0_dir_out,
    input  logic                      gp0_level,
    output logic [NPORTS-1:0]         fw_irq,
    output logic [NPORTS*CAUSE_W-1:0] trip_cause,
    output logic                      gp0_out,
    output logic                      gp0_oe
);
    logic tick;

    wdt_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        wdt_core #(.TMO_W(TMO_W), .CAUSE_W(CAUSE_W)) u_core (
            .clk          (clk),
            .rst_n        (rst_n),
            .tick_i       (tick),
            .dflt_en_i    (cfg_en_dflt),
            .dflt_tmo_i   (cfg_tmo_dflt),
            .setup_wr_i   (setup_wr[p]),
            .setup_en_i   (setup_en),
            .setup_tmo_i  (setup_tmo),
            .stat_wr_i    (stat_wr[p]),
            .stat_alive_i (stat_alive),
            .stat_force_i (stat_force),
            .stat_cause_i (stat_cause),
            .trip_o       (fw_irq[p]),
            .cause_o      (trip_cause[p*CAUSE_W +: CAUSE_W])
        );
    end

    wdt_pin #(.NPORTS(NPORTS)) u_pin (
        .trip_i     (fw_irq),
        .wdog_sel_i (gp0_wdog_sel),
        .dir_out_i  (gp0_dir_out),
        .level_i    (gp0_level),
        .pin_o      (gp0_out),
        .oe_o       (gp0_oe)
    );
endmodule

// File: tb/dual_wdt_test.sv
module dual_wdt_test;
    localparam int NP = 2;
    localparam int TW = 4;
    localparam int CW = 4;
    localparam int P  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en_dflt = 1'b1;
    logic [TW-1:0] cfg_tmo_dflt = 4'd3;
    logic [NP-1:0] setup_wr = '0;
    logic setup_en = 1'b0;
    logic [TW-1:0] setup_tmo = '0;
    logic [NP-1:0] stat_wr = '0;
    logic stat_alive = 1'b0, stat_force = 1'b0;
    logic [CW-1:0] stat_cause = '0;
    logic gp0_wdog_sel = 1'b0, gp0_dir_out = 1'b0, gp0_level = 1'b0;
    logic [NP-1:0] fw_irq;
    logic [NP*CW-1:0] trip_cause;
    logic gp0_out, gp0_oe;

    int checks = 0, fails = 0;
    int n = 0;

    always #10 clk = ~clk;
    always @(posedge clk) if (rst_n) n <= n + 1;

    dual_wdt #(.NPORTS(NP), .TMO_W(TW), .CAUSE_W(CW), .TICK_DIV(P)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_en_dflt(cfg_en_dflt), .cfg_tmo_dflt(cfg_tmo_dflt),
        .setup_wr(setup_wr), .setup_en(setup_en), .setup_tmo(setup_tmo),
        .stat_wr(stat_wr), .stat_alive(stat_alive), .stat_force(stat_force),
        .stat_cause(stat_cause), .gp0_wdog_sel(gp0_wdog_sel), .gp0_dir_out(gp0_dir_out),
        .gp0_level(gp0_level), .fw_irq(fw_irq), .trip_cause(trip_cause),
        .gp0_out(gp0_out), .gp0_oe(gp0_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // all write tasks start and end just after a falling edge
    task automatic do_setup(input int p, input bit en, input int tmo);
        setup_wr[p] = 1'b1; setup_en = en; setup_tmo = TW'(tmo);
        @(negedge clk);
        setup_wr = '0;
    endtask

    task automatic do_stat(input int p, input bit alive, input bit frc, input int cause);
        stat_wr[p] = 1'b1; stat_alive = alive; stat_force = frc; stat_cause = CW'(cause);
        @(negedge clk);
        stat_wr = '0; stat_alive = 1'b0; stat_force = 1'b0;
    endtask

    // watch port p for cyc cycles after it was (re)loaded on the last edge
    task automatic watch(input int p, input int tmo, input bit en, input int cyc, input string req);
        int ticks = 0;
        for (int i = 0; i < cyc; i++) begin
            chk(req, fw_irq[p], (en && tmo != 0 && ticks >= tmo) ? 1 : 0);
            if (n % P == P - 1) ticks++;
            @(negedge clk);
        end
    endtask

    function automatic int pin_exp(bit sel, bit dir, bit lvl, bit any);
        if (!dir) return 0;
        if (sel)  return any ? lvl : !lvl;
        return lvl;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 irq in reset", fw_irq, 0);
        chk("R1 cause in reset", trip_cause, 0);
        rst_n = 1'b1;
        // R1 and R3: defaults enable=1, timeout=3 expire without any write
        watch(0, 3, 1'b1, 20, "R1 default expiry");
        chk("R1 port1 default expiry", fw_irq[1], 1);

        // R2, R3, R7: sweep every timeout on port 0, port 1 disabled
        do_setup(1, 1'b0, 0);
        chk("R8 disable clears port1", fw_irq[1], 0);
        for (int t = 0; t < 16; t++) begin
            do_setup(0, 1'b0, 0);
            do_setup(0, 1'b1, t);
            watch(0, t, 1'b1, (t + 2) * P, t == 0 ? "R7 zero timeout" : "R2 R3 sweep");
            chk("R8 port1 disabled idle", fw_irq[1], 0);
        end

        // R8: disabled port does not count
        do_setup(0, 1'b0, 2);
        watch(0, 2, 1'b0, 5 * P, "R8 disabled no count");

        // R4: periodic re-arm keeps the port quiet
        do_setup(0, 1'b1, 5);
        for (int k = 0; k < 6; k++) begin
            watch(0, 5, 1'b1, 3 * P, "R4 rearm period");
            do_stat(0, 1'b1, 1'b0, k);
            chk("R6 cause follows write", trip_cause[CW-1:0], k);
        end
        watch(0, 5, 1'b1, 7 * P, "R3 expiry after rearm");
        // R8: held until re-armed
        repeat (40) @(negedge clk);
        chk("R8 irq held", fw_irq[0], 1);
        do_stat(0, 1'b1, 1'b0, 0);
        chk("R4 rearm clears irq", fw_irq[0], 0);

        // R5, R6: force trip with cause codes
        do_setup(0, 1'b1, 0);
        do_stat(0, 1'b0, 1'b1, 10);
        chk("R5 force trips port0", fw_irq[0], 1);
        chk("R6 cause port0", trip_cause[CW-1:0], 10);
        do_stat(0, 1'b1, 1'b1, 10);
        chk("R5 force beats alive", fw_irq[0], 1);
        do_stat(1, 1'b0, 1'b1, 5);
        chk("R8 force ignored when disabled", fw_irq[1], 0);
        chk("R6 cause port1", trip_cause[2*CW-1:CW], 5);
        chk("R6 cause port0 kept", trip_cause[CW-1:0], 10);
        do_setup(0, 1'b0, 0);
        chk("R8 disable clears trip", fw_irq[0], 0);

        // R9, R10, R11: pin controls against every trip pattern
        do_setup(1, 1'b1, 0);
        for (int c = 0; c < 4; c++) begin
            do_setup(0, 1'b0, 0);
            do_setup(1, 1'b0, 0);
            do_setup(0, 1'b1, 0);
            do_setup(1, 1'b1, 0);
            if (c[0]) do_stat(0, 1'b0, 1'b1, 1);
            if (c[1]) do_stat(1, 1'b0, 1'b1, 2);
            chk("R10 trip pattern", fw_irq, c);
            for (int m = 0; m < 8; m++) begin
                gp0_wdog_sel = m[0]; gp0_dir_out = m[1]; gp0_level = m[2];
                #1;
                chk("R9 oe", gp0_oe, m[1]);
                chk(m[0] ? "R10 pin wdog" : (m[1] ? "R11 pin gpio" : "R9 pin off"),
                    gp0_out, pin_exp(m[0], m[1], m[2], c != 0));
                @(negedge clk);
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule